// File: doc/BRIEF.md
# Burst Configuration Command Loader

This block sits beside a burst-capable memory and listens to the write cycles of an asynchronous command bus. When it sees three writes that form the configuration unlock sequence, it takes the setting carried in the upper address bits of the final write and stores it in a burst configuration register. The register drives the fields that the burst engine reads: a ready-timing bit, a 3-bit burst mode and a 3-bit wait-state code.

The write strobe is brought into the clock domain by a synchronizer, and each strobe pulse counts as exactly one write. Address and data must stay stable while the strobe is high. A write that breaks a sequence already in progress raises a one-cycle error pulse. Burst operation must not start before the register has been written, so the block also provides a burst-enable flag. This flag rises on the first completed load after reset and then stays high.

Top module: `burst_cfg_loader`

## Requirements
- R1: A load happens only after three writes in a row. Each write is compared on address bits 11:0 and on the data byte: first 555h with AAh, then 2AAh with 55h, then 555h with C0h. Address bits 18:12 are ignored on the first two writes.
- R2: On the load, address bit 18 of the third write goes to `rdy_early`, bits 17:15 go to `burst_mode` and bits 14:12 go to `wait_code`. All codes are stored exactly as written, including unassigned codes.
- R3: While reset is asserted, and after it is released, the outputs are: `rdy_early`=0 (ready arrives with data), `burst_mode`=000 (continuous), `wait_code`=011 (7-edge latency), `burst_en`=0 and `seq_err`=0.
- R4: A wrong second or third write sets `seq_err` high for exactly one cycle. It leaves the register unchanged and abandons the sequence. A completed load never raises `seq_err`.
- R5: A wrong second or third write that matches the first step starts a new sequence, so the next two correct writes complete a load.
- R6: With no sequence in progress, a write that does not match the first step raises no error and changes no output.
- R7: `burst_en` stays 0 from reset until the first completed load. It then stays 1 until the next reset.
- R8: A write's result appears on the outputs after the third rising clock edge following the strobe's rising edge. A strobe held high for many cycles counts as one write.
- R9: The configuration outputs change only on a completed load.
- R10: Reset discards any partly received sequence. After reset, a lone third-step write loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Asynchronous write strobe of the command bus, active high |
| cmd_addr | input | 19 | Command bus address, stable while the strobe is high |
| cmd_data | input | 8 | Command bus data, stable while the strobe is high |
| rdy_early | output | 1 | 1: ready is flagged one cycle before data; 0: ready comes with data |
| burst_mode | output | 3 | Burst mode code |
| wait_code | output | 3 | Initial-latency code |
| burst_en | output | 1 | High once a configuration has been loaded since reset |
| seq_err | output | 1 | One-cycle pulse when a sequence in progress is broken |

## Verification
Every result of a write, whether a register load, the error pulse or the burst-enable rise, is due after the third rising edge following the strobe's rise. Two of these edges belong to the synchronizer and one to the sequencer and register. The bench therefore sets the strobe at a falling edge, waits three rising edges and samples at the next falling edge. The error pulse lasts one cycle and is caught in that sampling window. The latency test also samples one edge early, to show that nothing has changed yet. It then holds the strobe for several more cycles to show that no second write is seen.

// File: rtl/bcl_pkg.sv
// Package: shared constants and types of the burst configuration loader.
// Assumes a 19-bit command address whose low 12 bits select the command
// step and whose upper 7 bits carry the setting on the final step.
package bcl_pkg;
    localparam int ADDR_W    = 19;
    localparam int DATA_W    = 8;
    localparam int KEY_W     = 12;
    localparam int SET_W     = ADDR_W - KEY_W;
    localparam int MODE_W    = 3;
    localparam int WAIT_W    = 3;

    // positions of fields inside the setting slice (address bits 18:12)
    localparam int RDY_POS   = SET_W - 1;
    localparam int MODE_LSB  = WAIT_W;
    localparam int WAIT_LSB  = 0;

    localparam logic [KEY_W-1:0]  STEP1_KEY  = 12'h555;
    localparam logic [DATA_W-1:0] STEP1_DATA = 8'hAA;
    localparam logic [KEY_W-1:0]  STEP2_KEY  = 12'h2AA;
    localparam logic [DATA_W-1:0] STEP2_DATA = 8'h55;
    localparam logic [KEY_W-1:0]  STEP3_KEY  = 12'h555;
    localparam logic [DATA_W-1:0] STEP3_DATA = 8'hC0;

    typedef struct packed {
        logic              rdy_early;
        logic [MODE_W-1:0] mode;
        logic [WAIT_W-1:0] wait_code;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_DEFAULT = '{rdy_early: 1'b0, mode: 3'b000, wait_code: 3'b011};

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GOT1 = 2'd1,
        SEQ_GOT2 = 2'd2
    } seq_state_t;
endpackage

// File: rtl/bcl_strobe_sync.sv
// Module: brings an asynchronous write strobe into the clock domain and
// turns each rising edge of it into a single-cycle write event.
// Assumes the strobe stays low for at least STAGES cycles between writes.
module bcl_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic write_evt
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // purpose: first sampling flop of the raw strobe
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= strobe_in;
                end
            end else begin : g_next
                // purpose: further metastability settling stage
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // purpose: remember the settled strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign write_evt = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bcl_step_seq.sv
// Module: three-step command sequencer. Tracks progress through the
// unlock sequence, requests a load on a correct third step and pulses an
// error when a sequence in progress is broken. A breaking write that
// matches step one restarts the sequence. Writes in idle that do not
// match step one are ignored silently.
// Assumes write_evt lasts one cycle and key/data are valid with it.
module bcl_step_seq
    import bcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              write_evt,
    input  logic [KEY_W-1:0]  key,
    input  logic [DATA_W-1:0] data,
    output logic              load,
    output logic              seq_err
);
    seq_state_t state_q, state_d;
    logic       hit1, hit2, hit3, brk;

    // purpose: compare the current write against each step pattern
    always_comb begin
        hit1 = (key == STEP1_KEY) && (data == STEP1_DATA);
        hit2 = (key == STEP2_KEY) && (data == STEP2_DATA);
        hit3 = (key == STEP3_KEY) && (data == STEP3_DATA);
    end

    // purpose: next-state, load request and break detection
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        brk     = 1'b0;
        if (write_evt) begin
            case (state_q)
                SEQ_IDLE: begin
                    if (hit1) state_d = SEQ_GOT1;
                end
                SEQ_GOT1: begin
                    if (hit2) begin
                        state_d = SEQ_GOT2;
                    end else begin
                        brk     = 1'b1;
                        state_d = hit1 ? SEQ_GOT1 : SEQ_IDLE;
                    end
                end
                SEQ_GOT2: begin
                    if (hit3) begin
                        load    = 1'b1;
                        state_d = SEQ_IDLE;
                    end else begin
                        brk     = 1'b1;
                        state_d = hit1 ? SEQ_GOT1 : SEQ_IDLE;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // purpose: hold sequence progress
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // purpose: register the single-cycle error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) seq_err <= 1'b0;
        else        seq_err <= brk;
    end
endmodule

// File: rtl/bcl_cfg_reg.sv
// Module: burst configuration register plus the sticky burst-enable flag.
// Splits the 7-bit setting into its fields on a load; holds otherwise.
// Assumes load is a single-cycle request from the sequencer.
module bcl_cfg_reg
    import bcl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SET_W-1:0] setting,
    output burst_cfg_t       cfg,
    output logic             burst_en
);
    burst_cfg_t next_cfg;

    // purpose: split the setting slice into its fields
    always_comb begin
        next_cfg.rdy_early = setting[RDY_POS];
        next_cfg.mode      = setting[MODE_LSB +: MODE_W];
        next_cfg.wait_code = setting[WAIT_LSB +: WAIT_W];
    end

    // purpose: configuration storage with reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg <= CFG_DEFAULT;
        else if (load) cfg <= next_cfg;
    end

    // purpose: flag that a configuration has been written since reset
    always_ff @(posedge clk) begin
        if (!rst_n)    burst_en <= 1'b0;
        else if (load) burst_en <= 1'b1;
    end
endmodule

// File: rtl/burst_cfg_loader.sv
// Module: top of the burst configuration command loader. Synchronizes
// the command bus strobe, runs the three-step sequencer and stores the
// setting from address bits 18:12 of the final step.
// Assumes address and data are stable while the strobe is high.
module burst_cfg_loader
    import bcl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rdy_early,
    output logic [MODE_W-1:0] burst_mode,
    output logic [WAIT_W-1:0] wait_code,
    output logic              burst_en,
    output logic              seq_err
);
    logic       write_evt;
    logic       seq_load;
    burst_cfg_t cfg;

    bcl_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (wr_strobe),
        .write_evt (write_evt)
    );

    bcl_step_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .write_evt (write_evt),
        .key       (cmd_addr[KEY_W-1:0]),
        .data      (cmd_data),
        .load      (seq_load),
        .seq_err   (seq_err)
    );

    bcl_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .setting  (cmd_addr[ADDR_W-1:KEY_W]),
        .cfg      (cfg),
        .burst_en (burst_en)
    );

    assign rdy_early  = cfg.rdy_early;
    assign burst_mode = cfg.mode;
    assign wait_code  = cfg.wait_code;
endmodule

// File: rtl/bcl_checker.sv
// Module: assertion checker for the burst configuration loader, bound to
// the top module. Observes ports and the sequencer's load request.
module bcl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic       rdy_early,
    input logic [2:0] burst_mode,
    input logic [2:0] wait_code,
    input logic       burst_en,
    input logic       seq_err
);
    // R3: defaults on the first cycle after reset release
    a_r3_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (rdy_early == 1'b0 && burst_mode == 3'b000 &&
                                    wait_code == 3'b011 && !burst_en && !seq_err));

    // R9: configuration holds unless a load was requested
    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({rdy_early, burst_mode, wait_code}));

    // R7: burst enable is sticky
    a_r7_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |=> burst_en);

    // R7: burst enable rises only through a load
    a_r7_en_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_en && !load) |=> !burst_en);

    // R4: error is a single-cycle pulse
    a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err);

    // R4: a completed load raises no error
    a_r4_load_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !seq_err);
endmodule

bind burst_cfg_loader bcl_checker u_bcl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (seq_load),
    .rdy_early  (rdy_early),
    .burst_mode (burst_mode),
    .wait_code  (wait_code),
    .burst_en   (burst_en),
    .seq_err    (seq_err)
);

// File: tb/burst_cfg_loader_bench.sv
module burst_cfg_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        rdy_early, burst_en, seq_err;
    logic [2:0]  burst_mode, wait_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    burst_cfg_loader u_burst_cfg_loader (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rdy_early(rdy_early), .burst_mode(burst_mode), .wait_code(wait_code),
        .burst_en(burst_en), .seq_err(seq_err)
    );

    // vector: {addr, data, exp rdy, exp mode, exp wait, exp err, exp en}
    localparam int NV = 20;
    localparam logic [35:0] VEC [NV] = '{
        {19'h00123, 8'h11, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0},  // R6 idle junk
        {19'h00555, 8'hAA, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0},
        {19'h002AA, 8'h55, 1'b0, 3'd0, 3'd3, 1'b0, 1'b0},
        {19'h4A555, 8'hC0, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},  // R1 R2 R7 load
        {19'h00555, 8'hAA, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},
        {19'h002AA, 8'hAA, 1'b1, 3'd1, 3'd2, 1'b1, 1'b1},  // R4 bad step 2
        {19'h20555, 8'hC0, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},  // R6 R9 lone step 3
        {19'h00555, 8'hAA, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},
        {19'h002AA, 8'h55, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},
        {19'h20555, 8'hC1, 1'b1, 3'd1, 3'd2, 1'b1, 1'b1},  // R4 bad step 3
        {19'h00555, 8'hAA, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},
        {19'h00555, 8'hAA, 1'b1, 3'd1, 3'd2, 1'b1, 1'b1},  // R5 restart
        {19'h002AA, 8'h55, 1'b1, 3'd1, 3'd2, 1'b0, 1'b1},
        {19'h20555, 8'hC0, 1'b0, 3'd4, 3'd0, 1'b0, 1'b1},  // R5 R2 load
        {19'h7F555, 8'hAA, 1'b0, 3'd4, 3'd0, 1'b0, 1'b1},  // R1 upper bits
        {19'h7F2AA, 8'h55, 1'b0, 3'd4, 3'd0, 1'b0, 1'b1},
        {19'h1B555, 8'hC0, 1'b0, 3'd3, 3'd3, 1'b0, 1'b1},  // R1 load
        {19'h00555, 8'hAA, 1'b0, 3'd3, 3'd3, 1'b0, 1'b1},
        {19'h002AA, 8'h55, 1'b0, 3'd3, 3'd3, 1'b0, 1'b1},
        {19'h7F555, 8'hC0, 1'b1, 3'd7, 3'd7, 1'b0, 1'b1}   // R2 unassigned codes
    };
    localparam string VTAG [NV] = '{
        "R6", "R1", "R1", "R2", "R1", "R4", "R9", "R1", "R1", "R4",
        "R5", "R5", "R5", "R5", "R1", "R1", "R1", "R1", "R1", "R2"
    };

    task automatic check(input string tag, input logic [8:0] exp);
        logic [8:0] act;
        act = {rdy_early, burst_mode, wait_code, seq_err, burst_en};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (rdy,mode,wait,err,en)", tag, act, exp);
        end
    endtask

    // raise strobe at a falling edge, return at the falling edge after the third rise
    task automatic strobe_on(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_addr = a;
        cmd_data = d;
        wr_strobe = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_off();
        wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        strobe_on(a, d);
        strobe_off();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R3 during reset", {1'b0, 3'd0, 3'd3, 1'b0, 1'b0});
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after reset", {1'b0, 3'd0, 3'd3, 1'b0, 1'b0});

        for (int i = 0; i < NV; i++) begin
            strobe_on(VEC[i][35:17], VEC[i][16:9]);
            check($sformatf("%s vector %0d", VTAG[i], i), VEC[i][8:0]);
            strobe_off();
        end

        // R10: reset in the middle of a sequence
        do_write(19'h00555, 8'hAA);
        do_write(19'h002AA, 8'h55);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 re-reset", {1'b0, 3'd0, 3'd3, 1'b0, 1'b0});
        rst_n = 1'b1;
        strobe_on(19'h4A555, 8'hC0);
        check("R10 lone step 3 after reset", {1'b0, 3'd0, 3'd3, 1'b0, 1'b0});
        strobe_off();

        // R8: latency and single event per long strobe
        do_write(19'h00555, 8'hAA);
        do_write(19'h002AA, 8'h55);
        @(negedge clk);
        cmd_addr = 19'h4A555;
        cmd_data = 8'hC0;
        wr_strobe = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 not yet after two edges", {1'b0, 3'd0, 3'd3, 1'b0, 1'b0});
        @(negedge clk);
        check("R8 due after third edge", {1'b1, 3'd1, 3'd2, 1'b0, 1'b1});
        repeat (8) @(negedge clk);
        check("R8 held strobe single write", {1'b1, 3'd1, 3'd2, 1'b0, 1'b1});
        strobe_off();

        // R7: burst enable stays high over a broken sequence
        do_write(19'h00555, 8'hAA);
        strobe_on(19'h00123, 8'h00);
        check("R7 R4 enable holds, error pulse", {1'b1, 3'd1, 3'd2, 1'b1, 1'b1});
        strobe_off();
        check("R4 error gone next write window", {1'b1, 3'd1, 3'd2, 1'b0, 1'b1});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule